// File: doc/BRIEF.md
# Accumulator-Headed Nibble Data Stack

This block is a 4-bit last-in-first-out data stack for a small processor datapath. The topmost element is held in a dedicated accumulator register, and every deeper element is kept in a 256 x 4-bit memory inside the block. An 8-bit pointer holds the memory address of the second element, not of the top. Because of this, an external ALU can read both operands, top and second, straight from registers.

A push stores the old top into memory one slot above the current second element. A pop moves the second element up into the accumulator and steps the pointer back. Reset does not place the stack anywhere useful, so the owner loads the pointer to choose where the stack area lies. All pointer arithmetic wraps around the 256-entry space without any indication. Each operation takes effect at one clock edge, and the outputs show the result in the following cycle.

Top module: `acc_stack`

## Requirements
- R1: After reset, `tos_o`, `nos_o` and `sp_o` are all zero and `err_o` is low.
- R2: A push (`push_i` high, `pop_i` and `sp_load_i` low) increments `sp_o` by one modulo 256, so 255 becomes 0.
- R3: On a push, `tos_o` takes `push_data_i`, `nos_o` takes the previous `tos_o`, and the previous `tos_o` is written to memory at the new `sp_o`.
- R4: A pop (`pop_i` high, `push_i` and `sp_load_i` low) moves the previous `nos_o` into `tos_o` and decrements `sp_o` by one modulo 256, so 0 becomes 255.
- R5: After a pop, `nos_o` equals the memory element at the new `sp_o`, which is the value most recently pushed to that address.
- R6: With `sp_load_i` high, `sp_o` takes `sp_value_i` and `nos_o` takes the memory element at that address, while `tos_o` is unchanged. Push and pop are ignored in that cycle and raise no error.
- R7: When `push_i` and `pop_i` are both high and `sp_load_i` is low, `tos_o`, `nos_o`, `sp_o` and the memory are unchanged, and `err_o` is high for exactly the next cycle.
- R8: With no strobe active, all outputs hold their values and `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | 4 | Value that becomes the new top on a push |
| sp_load_i | input | 1 | Load the pointer from `sp_value_i` |
| sp_value_i | input | 8 | New pointer value |
| tos_o | output | 4 | Top element (accumulator) |
| nos_o | output | 4 | Second element, located in memory at `sp_o` |
| sp_o | output | 8 | Address of the second element |
| err_o | output | 1 | One-cycle pulse after a push/pop clash |

## Verification
The assertions assume that the strobes are sampled only at clock edges and that a value read back from memory was written earlier in the run. Memory contents are not reset, so an element that was never written is undefined. For this reason the stimulus first makes 256 pushes from the reset pointer. These writes cover every address and also carry the pointer through its wrap. After that, random pushes, pops, loads and clashes run against a bench model of the whole memory, and directed cases cover the pointer wrap in both directions and a load issued together with push and pop.

// File: rtl/acc_stack_pkg.sv
package acc_stack_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_LOAD,
    OP_CLASH
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic pu, input logic po, input logic ld);
    if (ld)            return OP_LOAD;
    else if (pu && po) return OP_CLASH;
    else if (pu)       return OP_PUSH;
    else if (po)       return OP_POP;
    else               return OP_IDLE;
  endfunction

endpackage

// File: rtl/acc_stack_ram.sv
module acc_stack_ram #(
  parameter int DW = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem_q[raddr];
  end

endmodule

// File: rtl/acc_stack_ptr.sv
module acc_stack_ptr
  import acc_stack_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_inc,
  output logic [AW-1:0] sp_dec
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  assign sp_inc = sp_q + ONE;
  assign sp_dec = sp_q - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD: sp_q <= load_val;
        OP_PUSH: sp_q <= sp_inc;
        OP_POP:  sp_q <= sp_dec;
        default: sp_q <= sp_q;
      endcase
    end
  end

  // R6: a load takes the supplied value
  p_load_sp_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (sp_q == $past(load_val)));

endmodule

// File: rtl/acc_stack.sv
module acc_stack
  import acc_stack_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          sp_load_i,
  input  logic [AW-1:0] sp_value_i,
  output logic [DW-1:0] tos_o,
  output logic [DW-1:0] nos_o,
  output logic [AW-1:0] sp_o,
  output logic          err_o
);
  stk_op_e       op;
  logic [AW-1:0] sp_q, sp_inc, sp_dec;
  logic [DW-1:0] tos_q, nos_hold_q, ram_rdata;
  logic          nos_from_ram_q, err_q;
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_raddr;

  assign op = decode_op(push_i, pop_i, sp_load_i);

  acc_stack_ptr #(.AW(AW)) ptr_i (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (sp_value_i),
    .sp_q     (sp_q),
    .sp_inc   (sp_inc),
    .sp_dec   (sp_dec)
  );

  assign ram_we    = (op == OP_PUSH);
  assign ram_re    = (op == OP_POP) || (op == OP_LOAD);
  assign ram_raddr = (op == OP_LOAD) ? sp_value_i : sp_dec;

  acc_stack_ram #(.DW(DW), .AW(AW)) ram_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (sp_inc),
    .wdata (tos_q),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  // second element: pushed value held locally, or memory read register
  assign nos_o = nos_from_ram_q ? ram_rdata : nos_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q          <= '0;
      nos_hold_q     <= '0;
      nos_from_ram_q <= 1'b0;
      err_q          <= 1'b0;
    end else begin
      err_q <= (op == OP_CLASH);
      unique case (op)
        OP_PUSH: begin
          tos_q          <= push_data_i;
          nos_hold_q     <= tos_q;
          nos_from_ram_q <= 1'b0;
        end
        OP_POP: begin
          tos_q          <= nos_o;
          nos_from_ram_q <= 1'b1;
        end
        OP_LOAD: nos_from_ram_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign tos_o = tos_q;
  assign sp_o  = sp_q;
  assign err_o = err_q;

  // R2
  p_push_sp_r2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && !sp_load_i) |=> (sp_o == $past(sp_o) + 8'(1)));
  // R3
  p_push_tos_r3: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && !sp_load_i) |=> (tos_o == $past(push_data_i) && nos_o == $past(tos_o)));
  // R4
  p_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !sp_load_i) |=> (tos_o == $past(nos_o) && sp_o == $past(sp_o) - 8'(1)));
  // R6
  p_load_tos_r6: assert property (@(posedge clk) disable iff (rst)
    sp_load_i |=> ($stable(tos_o) && !err_o));
  // R7
  p_clash_r7: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !sp_load_i) |=> (err_o && $stable(tos_o) && $stable(sp_o) && $stable(nos_o)));
  // R8
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i && !sp_load_i) |=> (!err_o && $stable(tos_o) && $stable(sp_o) && $stable(nos_o)));

endmodule

// File: tb/acc_stack_tb_top.sv
module acc_stack_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       push_i, pop_i, sp_load_i;
  logic [3:0] push_data_i;
  logic [7:0] sp_value_i;
  logic [3:0] tos_o, nos_o;
  logic [7:0] sp_o;
  logic       err_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  logic [3:0] m_mem [256];
  logic [3:0] m_tos, m_nos;
  logic [7:0] m_sp;
  logic       m_err;

  always #10 clk = ~clk;

  acc_stack dut_i (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .sp_load_i(sp_load_i), .sp_value_i(sp_value_i),
    .tos_o(tos_o), .nos_o(nos_o), .sp_o(sp_o), .err_o(err_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "tos", tos_o, m_tos);
    chk(tag, "nos", nos_o, m_nos);
    chk(tag, "sp",  sp_o,  m_sp);
    chk(tag, "err", err_o, m_err);
  endtask

  function automatic void model(bit pu, bit po, bit ld, logic [3:0] d, logic [7:0] v);
    m_err = pu && po && !ld;
    if (ld) begin
      m_sp  = v;
      m_nos = m_mem[v];
    end else if (m_err) begin
      // no change
    end else if (pu) begin
      m_sp        = m_sp + 8'd1;
      m_mem[m_sp] = m_tos;
      m_nos       = m_tos;
      m_tos       = d;
    end else if (po) begin
      m_tos = m_nos;
      m_sp  = m_sp - 8'd1;
      m_nos = m_mem[m_sp];
    end
  endfunction

  task automatic step(bit pu, bit po, bit ld, logic [3:0] d, logic [7:0] v, string tag);
    push_i = pu; pop_i = po; sp_load_i = ld; push_data_i = d; sp_value_i = v;
    @(posedge clk);
    model(pu, po, ld, d, v);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; push_i = 0; pop_i = 0; sp_load_i = 0; push_data_i = 0; sp_value_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_tos = 0; m_nos = 0; m_sp = 0; m_err = 0;
    check_all("R1");
    // fill every memory address; pointer wraps 255 -> 0 (R2)
    for (int i = 0; i < 256; i++) step(1, 0, 0, 4'(i * 7 + 3), 8'h0, "R3");
    chk("R2", "sp after wrap", sp_o, 0);
    // directed: pop below zero wraps to 255 (R4, R5)
    step(0, 0, 1, 4'h0, 8'h00, "R6");
    step(0, 1, 0, 4'h0, 8'h00, "R4");
    chk("R4", "sp wrap down", sp_o, 255);
    step(0, 1, 0, 4'h0, 8'h00, "R5");
    // load together with push and pop: load wins, no error (R6)
    step(1, 1, 1, 4'h9, 8'h80, "R6");
    // clash then idle: single-cycle error pulse (R7, R8)
    step(1, 1, 0, 4'h5, 8'h00, "R7");
    step(0, 0, 0, 4'h5, 8'h00, "R8");
    // push at 255 wraps up (R2)
    step(0, 0, 1, 4'h0, 8'hFF, "R6");
    step(1, 0, 0, 4'hA, 8'h00, "R2");
    chk("R2", "sp wrap up", sp_o, 0);
    step(0, 1, 0, 4'h0, 8'h00, "R5");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 40)      step(1, 0, 0, 4'($urandom), 8'($urandom), "R3");
      else if (r < 80) step(0, 1, 0, 4'($urandom), 8'($urandom), "R5");
      else if (r < 87) step(0, 0, 1, 4'($urandom), 8'($urandom), "R6");
      else if (r < 93) step(1, 1, 0, 4'($urandom), 8'($urandom), "R7");
      else             step(0, 0, 0, 4'($urandom), 8'($urandom), "R8");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule